// File: doc/BRIEF.md
# PME Message Status Logger

This block sits behind a root port and records power-management-event (PME) messages that arrive from the downstream link. Each message is presented as a single-cycle valid strobe with a 16-bit requester ID. The block keeps a root status word holding a status flag, a pending flag and the requester ID that software should service. It also has a hidden slot that holds the ID of a later message while an earlier one is still outstanding.

When software clears the status flag with a write-1-to-clear, a pending entry is promoted into the visible word at once. Each time the status flag becomes newly set, the block raises an interrupt request, steered to MSI or to a pin. If interrupts are off, it sends an event to the power manager so that a GPE can be raised. Routing enables can also mark every PM event in an SCI status bit and in an SMI status bit, and the SMI bit drives the SMI request. An interrupt is also raised when software enables interrupts after a PME has already been logged.

A simple register port (write strobe, address, data; combinational read by address) gives software access. The register at address 0 is the root status word, address 1 is the control register, and address 2 is the SCI/SMI status word.

Top module: `pme_status_logger`

## Requirements
- R1: A PME message that arrives while the status flag is clear sets the status flag (status word bit 16) and stores its requester ID in status word bits 15:0. The pending flag (bit 17) reads 0.
- R2: A PME message that arrives while the status flag is set, with no clear in that cycle, sets the pending flag and stores its ID only in the hidden slot. The visible ID does not change, and no interrupt, GPE, SCI or SMI event results.
- R3: Writing 1 to bit 16 of address 0 while a message is pending leaves the status flag set and clears the pending flag. It moves the hidden ID into bits 15:0 and counts as a newly logged PME.
- R4: When a message arrives in the same cycle as a status clear, the pending entry is promoted first and the new ID goes to the hidden slot with the pending flag kept set. If nothing was pending, the new message is logged as a first message.
- R5: In the cycle after the status flag becomes newly set, if the interrupt enable (control bit 0) is 1, exactly one of two single-cycle pulses appears: msi_req when the MSI enable (control bit 1) is 1, otherwise pin_pulse. pin_irq is high whenever the status flag and the interrupt enable are 1 and the MSI enable is 0. Enable values are those in force after any write in the same cycle.
- R6: When the status flag becomes newly set while the interrupt enable is 0, gpe_evt pulses for one cycle and no interrupt pulse appears.
- R7: A write that changes the interrupt enable from 0 to 1 while the status flag is set produces one interrupt pulse in the following cycle, routed as in R5.
- R8: With the SCI routing enable (control bit 2) set, each newly logged PME sets the SCI status bit (bit 31 of address 2), which drives sci_out. Writing 1 to that bit clears it.
- R9: With the SMI routing enable (control bit 3) set, each newly logged PME sets the SMI status bit (bit 0 of address 2), which drives smi_out, whatever the other enables are. Writing 1 to that bit clears it.
- R10: The pending flag and the ID field are read-only, and writing 0 to the status flag has no effect. Control bits 3:0 read back what was written.
- R11: Reset clears every flag, the ID fields, the hidden slot, the control register and all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pme_valid | input | 1 | Decoded PME message strobe |
| pme_rid | input | 16 | Requester ID of the message |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| msi_req | output | 1 | One-cycle MSI request |
| pin_pulse | output | 1 | One-cycle pin interrupt request |
| pin_irq | output | 1 | Pin interrupt level |
| gpe_evt | output | 1 | One-cycle event to the power manager |
| sci_out | output | 1 | SCI request level |
| smi_out | output | 1 | SMI request level |

## Verification
The hardest situation to reach is a message that lands in the same cycle as a status clear while another ID is already waiting in the hidden slot. To reach it, the bench first logs one message and then parks a second one as pending. It then issues the clear and a third message on the same edge. Finally it clears again to show that the third ID, and not the second, comes out of the hidden slot. The enable register is also swept through all 16 settings around a first message, so that every combination of MSI, pin, GPE, SCI and SMI outcome is seen.

// File: rtl/pme_log_pkg.sv
package pme_log_pkg;
  localparam int ID_W     = 16;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 2;
  localparam logic [ADDR_W-1:0] A_ROOT = 2'd0;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd1;
  localparam logic [ADDR_W-1:0] A_PMST = 2'd2;
  localparam int ST_BIT   = 16;
  localparam int PD_BIT   = 17;
  localparam int SCI_BIT  = 31;
  localparam int SMI_BIT  = 0;
  localparam int CTL_W    = 4;

  typedef struct packed {
    logic smi_en;
    logic sci_en;
    logic msi_en;
    logic irq_en;
  } ctl_t;
endpackage

// File: rtl/pme_log_core.sv
module pme_log_core #(
  parameter int ID_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pme_valid,
  input  logic [ID_W-1:0] pme_rid,
  input  logic            clr_req,
  output logic            status_q,
  output logic            status_nx,
  output logic            pend_q,
  output logic [ID_W-1:0] vis_q,
  output logic [ID_W-1:0] hid_q,
  output logic            log_evt
);
  logic            pend_nx;
  logic [ID_W-1:0] vis_nx;
  logic [ID_W-1:0] hid_nx;
  logic            clr_hit;
  logic            upd_en;

  assign clr_hit = clr_req & status_q;
  assign upd_en  = pme_valid | clr_req;

  always_comb begin
    status_nx = status_q;
    pend_nx   = pend_q;
    vis_nx    = vis_q;
    hid_nx    = hid_q;
    log_evt   = 1'b0;
    if (clr_hit && pend_q) begin
      status_nx = 1'b1;
      pend_nx   = 1'b0;
      vis_nx    = hid_q;
      log_evt   = 1'b1;
      if (pme_valid) begin
        pend_nx = 1'b1;
        hid_nx  = pme_rid;
      end
    end else if (!status_q || clr_hit) begin
      status_nx = 1'b0;
      if (pme_valid) begin
        status_nx = 1'b1;
        vis_nx    = pme_rid;
        log_evt   = 1'b1;
      end
    end else if (pme_valid) begin
      pend_nx = 1'b1;
      hid_nx  = pme_rid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= 1'b0;
      pend_q   <= 1'b0;
      vis_q    <= '0;
      hid_q    <= '0;
    end else if (upd_en) begin
      status_q <= status_nx;
      pend_q   <= pend_nx;
      vis_q    <= vis_nx;
      hid_q    <= hid_nx;
    end
  end
endmodule

// File: rtl/pme_ctrl_regs.sv
module pme_ctrl_regs
  import pme_log_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_pmst,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              log_evt,
  output ctl_t              ctl_q,
  output ctl_t              ctl_nx,
  output logic              ie_rise,
  output logic              sci_st_q,
  output logic              smi_st_q
);
  logic sci_nx;
  logic smi_nx;
  logic st_en;

  assign st_en = wr_pmst | log_evt;

  always_comb begin
    ctl_nx = ctl_q;
    if (wr_ctrl) ctl_nx = ctl_t'(wr_data[CTL_W-1:0]);
    ie_rise = ctl_nx.irq_en & ~ctl_q.irq_en;

    sci_nx = sci_st_q;
    smi_nx = smi_st_q;
    if (wr_pmst && wr_data[SCI_BIT]) sci_nx = 1'b0;
    if (wr_pmst && wr_data[SMI_BIT]) smi_nx = 1'b0;
    if (log_evt && ctl_nx.sci_en)   sci_nx = 1'b1;
    if (log_evt && ctl_nx.smi_en)   smi_nx = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (wr_ctrl) begin
      ctl_q <= ctl_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sci_st_q <= 1'b0;
      smi_st_q <= 1'b0;
    end else if (st_en) begin
      sci_st_q <= sci_nx;
      smi_st_q <= smi_nx;
    end
  end
endmodule

// File: rtl/pme_irq_route.sv
module pme_irq_route (
  input  logic clk,
  input  logic rst_n,
  input  logic log_evt,
  input  logic status_nx,
  input  logic ie_nx,
  input  logic msi_en_nx,
  input  logic ie_rise,
  output logic msi_req,
  output logic pin_pulse,
  output logic gpe_evt
);
  logic trig;
  logic msi_nx;
  logic pin_nx;
  logic gpe_nx;

  always_comb begin
    trig   = ie_nx & (log_evt | (ie_rise & status_nx));
    msi_nx = trig & msi_en_nx;
    pin_nx = trig & ~msi_en_nx;
    gpe_nx = log_evt & ~ie_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msi_req   <= 1'b0;
      pin_pulse <= 1'b0;
      gpe_evt   <= 1'b0;
    end else begin
      msi_req   <= msi_nx;
      pin_pulse <= pin_nx;
      gpe_evt   <= gpe_nx;
    end
  end
endmodule

// File: rtl/pme_status_logger.sv
module pme_status_logger
  import pme_log_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pme_valid,
  input  logic [ID_W-1:0]   pme_rid,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              msi_req,
  output logic              pin_pulse,
  output logic              pin_irq,
  output logic              gpe_evt,
  output logic              sci_out,
  output logic              smi_out
);
  logic            clr_req;
  logic            wr_ctrl;
  logic            wr_pmst;
  logic            status_q;
  logic            status_nx;
  logic            pend_q;
  logic [ID_W-1:0] vis_q;
  logic [ID_W-1:0] hid_q;
  logic            log_evt;
  ctl_t            ctl_q;
  ctl_t            ctl_nx;
  logic            ie_rise;
  logic            sci_st_q;
  logic            smi_st_q;

  assign clr_req = wr_en && (wr_addr == A_ROOT) && wr_data[ST_BIT];
  assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
  assign wr_pmst = wr_en && (wr_addr == A_PMST);

  pme_log_core #(.ID_W(ID_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .pme_valid (pme_valid),
    .pme_rid   (pme_rid),
    .clr_req   (clr_req),
    .status_q  (status_q),
    .status_nx (status_nx),
    .pend_q    (pend_q),
    .vis_q     (vis_q),
    .hid_q     (hid_q),
    .log_evt   (log_evt)
  );

  pme_ctrl_regs #(.DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_ctrl  (wr_ctrl),
    .wr_pmst  (wr_pmst),
    .wr_data  (wr_data),
    .log_evt  (log_evt),
    .ctl_q    (ctl_q),
    .ctl_nx   (ctl_nx),
    .ie_rise  (ie_rise),
    .sci_st_q (sci_st_q),
    .smi_st_q (smi_st_q)
  );

  pme_irq_route u_route (
    .clk       (clk),
    .rst_n     (rst_n),
    .log_evt   (log_evt),
    .status_nx (status_nx),
    .ie_nx     (ctl_nx.irq_en),
    .msi_en_nx (ctl_nx.msi_en),
    .ie_rise   (ie_rise),
    .msi_req   (msi_req),
    .pin_pulse (pin_pulse),
    .gpe_evt   (gpe_evt)
  );

  assign pin_irq = status_q & ctl_q.irq_en & ~ctl_q.msi_en;
  assign sci_out = sci_st_q;
  assign smi_out = smi_st_q;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_ROOT: begin
        rd_data[ID_W-1:0] = vis_q;
        rd_data[ST_BIT]   = status_q;
        rd_data[PD_BIT]   = pend_q;
      end
      A_CTRL: rd_data[CTL_W-1:0] = ctl_q;
      A_PMST: begin
        rd_data[SCI_BIT] = sci_st_q;
        rd_data[SMI_BIT] = smi_st_q;
      end
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/pme_status_logger_chk.sv
module pme_status_logger_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        pme_valid,
  input logic [15:0] pme_rid,
  input logic        clr_req,
  input logic        status_q,
  input logic        pend_q,
  input logic [15:0] vis_q,
  input logic [15:0] hid_q,
  input logic        msi_req,
  input logic        pin_pulse,
  input logic        gpe_evt
);
  // R1
  first_log_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_q && pme_valid) |=> (status_q && vis_q == $past(pme_rid)));

  // R2
  second_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q && pme_valid && !clr_req) |=> (pend_q && $stable(vis_q) && hid_q == $past(pme_rid)));

  // R3
  promote_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q && pend_q && clr_req && !pme_valid) |=> (status_q && !pend_q && vis_q == $past(hid_q)));

  // R4
  clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q && pend_q && clr_req && pme_valid) |=> (pend_q && hid_q == $past(pme_rid)));

  // R5
  one_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({msi_req, pin_pulse, gpe_evt}));

  // R2
  no_event_on_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q && !pend_q && pme_valid && !clr_req) |=> !gpe_evt);
endmodule

bind pme_status_logger pme_status_logger_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pme_valid (pme_valid),
  .pme_rid   (pme_rid),
  .clr_req   (clr_req),
  .status_q  (status_q),
  .pend_q    (pend_q),
  .vis_q     (vis_q),
  .hid_q     (hid_q),
  .msi_req   (msi_req),
  .pin_pulse (pin_pulse),
  .gpe_evt   (gpe_evt)
);

// File: tb/pme_status_logger_tb.sv
module pme_status_logger_tb;
  logic        clk;
  logic        rst_n;
  logic        pme_valid;
  logic [15:0] pme_rid;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [31:0] wr_data;
  logic [1:0]  rd_addr;
  logic [31:0] rd_data;
  logic        msi_req, pin_pulse, pin_irq, gpe_evt, sci_out, smi_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  pme_status_logger u_dut (
    .clk(clk), .rst_n(rst_n), .pme_valid(pme_valid), .pme_rid(pme_rid),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .msi_req(msi_req), .pin_pulse(pin_pulse), .pin_irq(pin_irq),
    .gpe_evt(gpe_evt), .sci_out(sci_out), .smi_out(smi_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input logic pv, input logic [15:0] rid,
                      input logic we, input logic [1:0] wa, input logic [31:0] wd);
    @(negedge clk);
    pme_valid = pv; pme_rid = rid; wr_en = we; wr_addr = wa; wr_data = wd;
    @(posedge clk);
    #2;
    pme_valid = 1'b0; wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic outs(input string req, input logic m, input logic p, input logic g);
    chk({req, " msi_req"}, {31'b0, msi_req}, {31'b0, m});
    chk({req, " pin_pulse"}, {31'b0, pin_pulse}, {31'b0, p});
    chk({req, " gpe_evt"}, {31'b0, gpe_evt}, {31'b0, g});
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [15:0] id;
    rst_n = 1'b0; pme_valid = 1'b0; pme_rid = '0; wr_en = 1'b0;
    wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(posedge clk);
    #2;
    // R11 reset state
    rd(2'd0, v); chk("R11 root", v, 32'h0);
    rd(2'd1, v); chk("R11 ctrl", v, 32'h0);
    rd(2'd2, v); chk("R11 pmst", v, 32'h0);
    chk("R11 outs", {26'b0, msi_req, pin_pulse, pin_irq, gpe_evt, sci_out, smi_out}, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    // Sweep all enable settings around a first message: R1 R5 R6 R8 R9 R10
    for (int c = 0; c < 16; c++) begin
      tick(0, 0, 1, 2'd1, 32'(c));
      tick(0, 0, 1, 2'd0, 32'h0001_0000);
      tick(0, 0, 1, 2'd2, 32'h8000_0001);
      rd(2'd1, v); chk("R10 ctrl readback", v, 32'(c));
      id = 16'(c * 16'h1111 + 16'h0005);
      tick(1, id, 0, 0, 0);
      rd(2'd0, v); chk("R1 first log", v, {15'b0, 1'b1, id});
      outs("R5/R6 route", c[0] & c[1], c[0] & ~c[1], ~c[0]);
      chk("R5 pin level", {31'b0, pin_irq}, {31'b0, c[0] & ~c[1]});
      rd(2'd2, v); chk("R8/R9 pm status", v, {c[2], 30'b0, c[3]});
      chk("R8 sci_out", {31'b0, sci_out}, {31'b0, c[2]});
      chk("R9 smi_out", {31'b0, smi_out}, {31'b0, c[3]});
      tick(0, 0, 0, 0, 0);
      outs("R5 single-cycle pulse", 0, 0, 0);
    end

    // W1C of SCI/SMI status: R8 R9
    tick(0, 0, 1, 2'd2, 32'h8000_0000);
    rd(2'd2, v); chk("R8 sci clear", v, 32'h0000_0001);
    tick(0, 0, 1, 2'd2, 32'h0000_0001);
    rd(2'd2, v); chk("R9 smi clear", v, 32'h0);

    // Late enable: R7
    tick(0, 0, 1, 2'd0, 32'h0001_0000);
    tick(0, 0, 1, 2'd1, 32'h0);
    tick(1, 16'hABCD, 0, 0, 0);
    outs("R6 gpe when disabled", 0, 0, 1);
    tick(0, 0, 1, 2'd1, 32'h1);
    outs("R7 late enable pin", 0, 1, 0);
    chk("R7 pin level", {31'b0, pin_irq}, 32'h1);
    tick(0, 0, 1, 2'd1, 32'h0);
    tick(0, 0, 1, 2'd1, 32'h3);
    outs("R7 late enable msi", 1, 0, 0);

    // R10 read-only fields and zero write to status
    tick(0, 0, 1, 2'd0, 32'h0002_FFFF);
    rd(2'd0, v); chk("R10 ro fields", v, 32'h0001_ABCD);

    // Pending and promotion: R2 R3
    tick(0, 0, 1, 2'd1, 32'h1);
    tick(0, 0, 1, 2'd0, 32'h0001_0000);
    tick(1, 16'h1234, 0, 0, 0);
    outs("R5 pin on first", 0, 1, 0);
    tick(1, 16'h5678, 0, 0, 0);
    outs("R2 no event", 0, 0, 0);
    rd(2'd0, v); chk("R2 pending", v, 32'h0003_1234);
    tick(0, 0, 1, 2'd0, 32'h0001_0000);
    outs("R3 promote irq", 0, 1, 0);
    rd(2'd0, v); chk("R3 promoted", v, 32'h0001_5678);

    // Same-cycle clear and message with pending: R4
    tick(1, 16'h9ABC, 0, 0, 0);
    tick(1, 16'hDEF0, 1, 2'd0, 32'h0001_0000);
    rd(2'd0, v); chk("R4 promote then park", v, 32'h0003_9ABC);
    outs("R4 promote irq", 0, 1, 0);
    tick(0, 0, 1, 2'd0, 32'h0001_0000);
    rd(2'd0, v); chk("R4 newest in hidden", v, 32'h0001_DEF0);

    // Same-cycle clear and message, nothing pending: R4
    tick(1, 16'h0F0F, 1, 2'd0, 32'h0001_0000);
    rd(2'd0, v); chk("R4 first after clear", v, 32'h0001_0F0F);
    outs("R4 first irq", 0, 1, 0);

    // Plain clear, no pending
    tick(0, 0, 1, 2'd0, 32'h0001_0000);
    rd(2'd0, v); chk("R10 status w1c", v, 32'h0000_0F0F);
    chk("R5 pin level low", {31'b0, pin_irq}, 32'h0);

    // Reset mid-operation: R11
    tick(1, 16'h1111, 0, 0, 0);
    tick(1, 16'h2222, 0, 0, 0);
    @(negedge clk); rst_n = 1'b0;
    #2;
    rd(2'd0, v); chk("R11 reset root", v, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    tick(0, 0, 1, 2'd0, 32'h0001_0000);
    rd(2'd0, v); chk("R11 hidden cleared", v, 32'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule